// File: doc/BRIEF.md
# Gated Entropy CRC Accumulator with Read Interlock

This block folds three single-bit noise streams into a 64-bit CRC register, one bit per clock. Each stream passes through its own enable gate; the gated bits are combined by exclusive-OR into one bit. That bit enters the CRC feedback path. The CRC register is the block's only data word, and it can only be read.

A control word, written through a one-cycle write strobe, holds the three stream enables, a mode bit and a minimum-wait count. With the mode bit set, a read request stays stalled, with its ready low, until the wait count has elapsed since the last completed read or since reset. This gives the register time to take in fresh bits between reads. With the mode bit clear, every read completes in the cycle it is requested. The read data is the CRC value in the cycle the read completes.

Top module: `entropy_crc_acc`

## Requirements
- R1: A synchronous active-low reset clears the CRC to zero, the cycle counter to zero and the whole control word, so after reset every enable is off and the mode bit is clear.
- R2: Control word bit i (i = 0, 1, 2) enables noise input `src_bits[i]`. A disabled input has no effect on the CRC.
- R3: The bits of the enabled inputs are XORed into one feed bit. When no input is enabled the feed bit is 0, and a CRC that is zero then stays zero.
- R4: Each clock the CRC takes one step. With f = CRC[63] XOR feed bit, the next CRC is (CRC shifted left by one, bit 0 filled with 0), XORed with 64'h231DCEE91262B8A3 when f is 1. That constant is the low 64 bits of the degree-64 polynomial with terms 64, 61, 57, 56, 52, 51, 50, 48, 47, 46, 43, 42, 41, 39, 38, 37, 35, 32, 28, 25, 22, 21, 17, 15, 13, 12, 11, 7, 5, 1 and 0.
- R5: `rd_data` always shows the current CRC register. A read completes in a cycle where `rd_req` and `rd_ready` are both high, and it returns that cycle's value.
- R6: With the mode bit (control bit 3) clear, `rd_ready` equals `rd_req` in the same cycle. `rd_ready` is never high without `rd_req`.
- R7: With the mode bit set, `rd_ready` is high only when the cycle counter is at least the wait field (control bits 23:8). The counter counts clocks since the last completed read or since reset.
- R8: The counter returns to zero on the clock after a completed read. Otherwise it increases by one each clock and saturates at its maximum.
- R9: A control write (`ctl_wr` high) takes effect at the next clock edge. A wait field of 0 with the mode bit set lets reads complete immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_bits | input | 3 | Raw noise bits, one per source |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word: [2:0] enables, [3] mode, [23:8] wait |
| rd_req | input | 1 | Data read request, held until ready |
| rd_ready | output | 1 | Read completes this cycle |
| rd_data | output | 64 | Current CRC register value |

## Verification
The CRC is driven with random noise on all three inputs while the enables are set to each single source, to all three, and to none. The single-source runs show whether each enable selects its own input and no other. The all-three run tests the XOR combine. The no-source run, started from a nonzero CRC, shows pure polynomial shifting, and from zero it shows that the register holds at zero. Reads are then made in held-request, back-to-back and idle-gap patterns under interlock waits of 0 and 5 and with the interlock off. These separate an off-by-one counter compare, a counter that fails to restart after a read, and a mode bit that is ignored.

// File: rtl/entropy_acc_pkg.sv
// Shared constants for the entropy CRC accumulator.
// Assumes a 64-bit CRC and a 32-bit control word with fixed field offsets.
package entropy_acc_pkg;
    localparam int CRC_W    = 64;
    localparam int NUM_SRC  = 3;
    localparam int CTL_W    = 32;
    localparam int WAIT_W   = 16;
    localparam int EN_LSB   = 0;
    localparam int MODE_BIT = 3;
    localparam int WAIT_LSB = 8;
    // Low 64 bits of the feedback polynomial (x^64 term implied)
    localparam logic [CRC_W-1:0] CRC_POLY = 64'h231D_CEE9_1262_B8A3;
endpackage

// File: rtl/eca_ctrl_reg.sv
// Control register: holds the source enables, the interlock mode and the wait count.
// Assumes a single-cycle write strobe; there is no readback path.
module eca_ctrl_reg #(
    parameter int NSRC  = entropy_acc_pkg::NUM_SRC,
    parameter int DW    = entropy_acc_pkg::CTL_W,
    parameter int WW    = entropy_acc_pkg::WAIT_W,
    parameter int EN_LO = entropy_acc_pkg::EN_LSB,
    parameter int MODEB = entropy_acc_pkg::MODE_BIT,
    parameter int WT_LO = entropy_acc_pkg::WAIT_LSB
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [DW-1:0]   wdata,
    output logic [NSRC-1:0] en,
    output logic            mode,
    output logic [WW-1:0]   wait_cyc
);
    // Load all fields on a write, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= '0;
            mode     <= 1'b0;
            wait_cyc <= '0;
        end else if (wr) begin
            en       <= wdata[EN_LO +: NSRC];
            mode     <= wdata[MODEB];
            wait_cyc <= wdata[WT_LO +: WW];
        end
    end

    p_ctl_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (en == $past(wdata[EN_LO +: NSRC])) && (wait_cyc == $past(wdata[WT_LO +: WW])));
    p_ctl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && rst_n) |=> $stable(mode) && $stable(en));
endmodule

// File: rtl/eca_src_mix.sv
// Gates each noise bit with its enable and folds the survivors into one bit by XOR.
// Assumes the noise bits are already synchronous to clk.
module eca_src_mix #(
    parameter int NSRC = entropy_acc_pkg::NUM_SRC
) (
    input  logic [NSRC-1:0] src,
    input  logic [NSRC-1:0] en,
    output logic            mix
);
    logic [NSRC-1:0] gated;

    // One AND gate per source
    for (genvar g = 0; g < NSRC; g++) begin : g_gate
        assign gated[g] = src[g] & en[g];
    end

    // Parity of the gated sources
    assign mix = ^gated;

    always_comb begin
        if (en == '0) p_none_zero_r3: assert (mix == 1'b0);
    end
endmodule

// File: rtl/eca_crc_lfsr.sv
// Serial CRC register: one feed bit per clock with MSB-first feedback.
// Assumes the polynomial's top term is implied and only its low W bits are given.
module eca_crc_lfsr #(
    parameter int             W    = entropy_acc_pkg::CRC_W,
    parameter logic [W-1:0]   POLY = entropy_acc_pkg::CRC_POLY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_in,
    output logic [W-1:0] crc
);
    logic fb;
    assign fb = crc[W-1] ^ bit_in;

    // Shift one step per clock, applying the polynomial on feedback
    always_ff @(posedge clk) begin
        if (!rst_n) crc <= '0;
        else        crc <= {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    p_zero_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (crc == '0 && !bit_in) |=> crc == '0);
    p_lsb_tracks_fb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> crc[0] == $past(crc[W-1] ^ bit_in));
endmodule

// File: rtl/eca_read_gate.sv
// Read interlock: counts clocks since the last completed read and grants ready.
// Assumes rd_req is held high by the requester until ready is seen.
module eca_read_gate #(
    parameter int CW = entropy_acc_pkg::WAIT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic          mode,
    input  logic [CW-1:0] wait_cyc,
    output logic          rd_ready
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] cnt;
    logic          done;

    // Grant when the interlock is off or enough clocks have passed
    assign rd_ready = rd_req && (!mode || (cnt >= wait_cyc));
    assign done     = rd_req && rd_ready;

    // Restart after a completed read, otherwise count up and saturate
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (done)           cnt <= '0;
        else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cnt == '0);
    p_count_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !done && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);
    p_ready_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> rd_req);
    p_open_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !mode) |-> rd_ready);
endmodule

// File: rtl/entropy_crc_acc.sv
// Top level: control register, source mixer, serial CRC and read interlock.
// Assumes all inputs are synchronous to clk; rd_data always shows the CRC.
module entropy_crc_acc #(
    parameter int NSRC = entropy_acc_pkg::NUM_SRC,
    parameter int DW   = entropy_acc_pkg::CTL_W,
    parameter int CRCW = entropy_acc_pkg::CRC_W,
    parameter int WW   = entropy_acc_pkg::WAIT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_bits,
    input  logic            ctl_wr,
    input  logic [DW-1:0]   ctl_wdata,
    input  logic            rd_req,
    output logic            rd_ready,
    output logic [CRCW-1:0] rd_data
);
    logic [NSRC-1:0] en;
    logic            mode;
    logic [WW-1:0]   wait_cyc;
    logic            mix;

    eca_ctrl_reg #(.NSRC(NSRC), .DW(DW), .WW(WW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
        .en(en), .mode(mode), .wait_cyc(wait_cyc)
    );

    eca_src_mix #(.NSRC(NSRC)) u_mix (
        .src(src_bits), .en(en), .mix(mix)
    );

    eca_crc_lfsr #(.W(CRCW)) u_crc (
        .clk(clk), .rst_n(rst_n), .bit_in(mix), .crc(rd_data)
    );

    eca_read_gate #(.CW(WW)) u_gate (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .mode(mode),
        .wait_cyc(wait_cyc), .rd_ready(rd_ready)
    );

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0) && (en == '0) && !mode);
endmodule

// File: tb/entropy_crc_acc_tb.sv
// Bench: behavioural reference model compared on every clock.
module entropy_crc_acc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  src_bits = '0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic        rd_req = 1'b0;
    logic        rd_ready;
    logic [63:0] rd_data;

    int n_vec = 0;
    int n_bad = 0;
    string req_tag = "R1";

    // reference state
    logic [63:0] m_crc = '0;
    int          m_cnt = 0;
    logic [2:0]  m_en = '0;
    logic        m_mode = 1'b0;
    int          m_wait = 0;
    logic [63:0] m_poly;

    always #10 clk = ~clk;

    entropy_crc_acc u_dut (
        .clk(clk), .rst_n(rst_n), .src_bits(src_bits), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .rd_req(rd_req), .rd_ready(rd_ready), .rd_data(rd_data)
    );

    function automatic logic [63:0] build_poly();
        int exps[30] = '{61,57,56,52,51,50,48,47,46,43,42,41,39,38,37,35,
                         32,28,25,22,21,17,15,13,12,11,7,5,1,0};
        logic [63:0] p = '0;
        foreach (exps[k]) p[exps[k]] = 1'b1;
        return p;
    endfunction

    // compare outputs, then advance model over the next clock edge
    task automatic step();
        logic exp_rdy;
        logic feed;
        logic f;
        #1;
        if (rst_n) begin
            exp_rdy = rd_req && (!m_mode || m_cnt >= m_wait);
            n_vec++;
            if (rd_ready !== exp_rdy) begin
                n_bad++;
                $display("FAIL %s rd_ready got %b exp %b", req_tag, rd_ready, exp_rdy);
            end
            n_vec++;
            if (rd_data !== m_crc) begin
                n_bad++;
                $display("FAIL %s rd_data got %h exp %h", req_tag, rd_data, m_crc);
            end
        end else begin
            exp_rdy = 1'b0;
        end
        @(posedge clk);
        if (!rst_n) begin
            m_crc = '0; m_cnt = 0; m_en = '0; m_mode = 1'b0; m_wait = 0;
        end else begin
            feed = 1'b0;
            for (int i = 0; i < 3; i++) if (m_en[i]) feed = feed ^ src_bits[i];
            f = m_crc[63] ^ feed;
            m_crc = m_crc << 1;
            if (f) m_crc = m_crc ^ m_poly;
            if (exp_rdy) m_cnt = 0;
            else if (m_cnt < 65535) m_cnt = m_cnt + 1;
            if (ctl_wr) begin
                m_en = ctl_wdata[2:0];
                m_mode = ctl_wdata[3];
                m_wait = int'(ctl_wdata[23:8]);
            end
        end
        @(negedge clk);
    endtask

    task automatic write_ctl(input logic [2:0] en, input logic md, input int wt);
        ctl_wr = 1'b1;
        ctl_wdata = {8'h00, wt[15:0], 4'h0, md, en};
        step();
        ctl_wr = 1'b0;
        ctl_wdata = '0;
    endtask

    task automatic run_noise(input int n);
        for (int i = 0; i < n; i++) begin
            src_bits = 3'($urandom);
            step();
        end
    endtask

    initial begin
        m_poly = build_poly();
        #190000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) step();
        rst_n = 1'b1;
        // R1: reset state, noise present but nothing enabled, open reads
        req_tag = "R1";
        for (int i = 0; i < 6; i++) begin
            src_bits = 3'($urandom);
            rd_req = i[0];
            step();
        end
        rd_req = 1'b0;
        // R2: each source alone
        req_tag = "R2";
        write_ctl(3'b001, 1'b0, 0); run_noise(40);
        write_ctl(3'b010, 1'b0, 0); run_noise(40);
        write_ctl(3'b100, 1'b0, 0); run_noise(40);
        // R3/R4: all three combined
        req_tag = "R3";
        write_ctl(3'b111, 1'b0, 0); run_noise(80);
        // R4: no sources, nonzero CRC shifts through polynomial
        req_tag = "R4";
        write_ctl(3'b000, 1'b0, 0); run_noise(70);
        // R3: zero CRC stays zero with nothing enabled
        req_tag = "R3";
        rst_n = 1'b0; step(); rst_n = 1'b1;
        run_noise(20);
        // R7/R8: interlock with wait 5, held and back-to-back requests
        req_tag = "R7";
        write_ctl(3'b111, 1'b1, 5);
        rd_req = 1'b1;
        run_noise(30);
        req_tag = "R8";
        rd_req = 1'b0; run_noise(9);
        rd_req = 1'b1; run_noise(8);
        rd_req = 1'b0; run_noise(2);
        rd_req = 1'b1; run_noise(10);
        // R9: wait 0 with interlock on, and write timing
        req_tag = "R9";
        write_ctl(3'b101, 1'b1, 0);
        run_noise(10);
        // R6: interlock off, continuous and gapped requests
        req_tag = "R6";
        write_ctl(3'b011, 1'b0, 200);
        run_noise(10);
        rd_req = 1'b0; run_noise(3);
        rd_req = 1'b1; run_noise(5);
        // R5: data visible on completed reads under long wait
        req_tag = "R5";
        write_ctl(3'b110, 1'b1, 12);
        run_noise(40);
        rd_req = 1'b0;
        run_noise(4);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule